// File: doc/BRIEF.md
# Triggerable Period Timer Counter

This block is an up-counter with a programmable period. It counts while it is operating. When the count matches the period value it wraps to zero and raises a one-cycle overflow pulse. In auto-reload mode the count keeps going after each wrap. In one-shot mode, if the period-interrupt enable is also set, the first wrap halts the counter and clears the run bit.

Software starts and stops the counter through a run bit. A stop freezes the count, and a later start resumes from the frozen value. A strobe on the counter write port clears the count to zero, but only while the counter is stopped. A status output reports whether the counter is actually operating, separately from the run request.

When trigger gating is enabled, a selected trigger input also drives the run bit. The trigger can start the counter, stop it, or toggle it. The trigger inputs can carry an external interrupt, a timer interrupt or a peer timer's trigger.

Top module: `tpt_top`

## Requirements
- R1: While the status output is 1, the count increases by one on every clock. A software start (run write with data 1) sets the run bit on the edge that samples the write. The first increment lands two edges after that.
- R2: On a clock where the counter is operating and the count equals the period value, the count becomes 0 and the overflow output is 1 for exactly that following cycle. A period of 0 therefore gives overflow on every operating cycle. A period of P gives one overflow every P+1 operating cycles.
- R3: With one-shot mode off, or with one-shot mode on but the period-interrupt enable off, the counter keeps counting after a wrap and the run bit stays 1.
- R4: With one-shot mode on and the period-interrupt enable on, a wrap clears the run bit and the status bit on the same edge. The count then stays at 0.
- R5: A software stop (run write with data 0) clears the run bit at once. The counter still advances on the next edge, then holds its value while stopped. A later start resumes from the held value.
- R6: A counter write strobe while the status bit is 0 clears the count to 0, whatever the data. While the status bit is 1 the strobe is ignored and counting continues undisturbed.
- R7: The status bit follows the run bit one clock later, except that a one-shot halt clears both together.
- R8: With trigger gating on, only a rising edge of the trigger input whose index equals the source select acts. A level held high acts once. Other inputs, and any input while gating is off, have no effect.
- R9: The trigger action code selects what happens: 0 sets the run bit, 1 clears it, 2 inverts it, and 3 leaves it unchanged.
- R10: A software run write in the same cycle as an active trigger wins over the trigger. A one-shot halt wins over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_i | input | CNT_W | Period value (the count wraps on match) |
| oneshot_i | input | 1 | 1 selects one-shot mode, 0 selects auto-reload |
| pie_i | input | 1 | Period-interrupt enable (needed for a one-shot halt) |
| run_wr_i | input | 1 | Strobe that writes the run bit |
| run_wdata_i | input | 1 | Value written to the run bit |
| cnt_wr_i | input | 1 | Counter write strobe (clears the count when stopped) |
| trig_en_i | input | 1 | Enables trigger gating |
| trig_src_i | input | SRC_W | Index of the trigger input in use |
| trig_act_i | input | 2 | Trigger action: 0 start, 1 stop, 2 toggle, 3 none |
| trig_i | input | N_SRC | Trigger inputs (level, edge-detected) |
| run_o | output | 1 | Run bit readback |
| active_o | output | 1 | Status: counter operating |
| count_o | output | CNT_W | Current count |
| ovf_o | output | 1 | One-cycle overflow pulse |

## Verification
The counting function is tried in four ways. A long run with a stop and a restart separates holding the count from clearing it. Runs with a small period compare auto-reload against one-shot with the interrupt enable off and on, so a halt that ignores the enable shows up. A period of zero exposes an off-by-one in the match. The trigger patterns are a non-selected input, a held level, each action code, gating off, and a trigger in the same cycle as a software write. Together they tell apart edge and level detection, wrong source decoding, and the wrong priority between software and trigger.

// File: rtl/tpt_pkg.sv
// Package: shared types of the triggerable period timer.
// Assumes: imported by every module of the block.
package tpt_pkg;
    // Effect of a selected trigger event on the run bit
    typedef enum logic [1:0] {
        TA_START  = 2'd0,
        TA_STOP   = 2'd1,
        TA_TOGGLE = 2'd2,
        TA_NONE   = 2'd3
    } trig_act_e;
endpackage

// File: rtl/tpt_trig_sel.sv
// Module: per-input rising-edge detection and source selection.
// Assumes: trigger inputs are synchronous to clk. A select value beyond
// N_SRC-1 picks no source.
module tpt_trig_sel #(
    parameter int N_SRC = 4,
    parameter int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] trig_i,
    input  logic [SRC_W-1:0] sel_i,
    output logic             pulse_o
);
    logic [N_SRC-1:0] prev_q;
    logic [N_SRC-1:0] rise;

    // One edge detector per trigger input
    for (genvar g = 0; g < N_SRC; g++) begin : g_edge
        // Remember the last level of this input
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= trig_i[g];
        end
        assign rise[g] = trig_i[g] & ~prev_q[g];
    end

    // Pick the rising edge of the selected source
    always_comb begin
        pulse_o = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel_i == SRC_W'(i)) pulse_o = rise[i];
        end
    end

    // R8: a single input cannot produce an event on two consecutive cycles
    a_r8_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !(pulse_o && $stable(sel_i)));
endmodule

// File: rtl/tpt_run_ctrl.sv
// Module: run bit and operating status.
// Assumes: halt_i comes from the counter and is high only on an operating
// cycle that wraps in one-shot mode with the interrupt enable set.
// Priority: halt, then software write, then trigger.
module tpt_run_ctrl
    import tpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_wr_i,
    input  logic       run_wdata_i,
    input  logic       trig_en_i,
    input  logic [1:0] trig_act_i,
    input  logic       trig_pulse_i,
    input  logic       halt_i,
    output logic       run_o,
    output logic       active_o
);
    logic      run_q;
    logic      active_q;
    logic      run_d;
    trig_act_e act;

    assign act = trig_act_e'(trig_act_i);

    // Next value of the run bit under the priority order
    always_comb begin
        run_d = run_q;
        if (halt_i) begin
            run_d = 1'b0;
        end else if (run_wr_i) begin
            run_d = run_wdata_i;
        end else if (trig_en_i && trig_pulse_i) begin
            case (act)
                TA_START:  run_d = 1'b1;
                TA_STOP:   run_d = 1'b0;
                TA_TOGGLE: run_d = ~run_q;
                default:   run_d = run_q;
            endcase
        end
    end

    // Run bit register and the status that follows it one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            active_q <= 1'b0;
        end else begin
            run_q    <= run_d;
            active_q <= halt_i ? 1'b0 : run_q;
        end
    end

    assign run_o    = run_q;
    assign active_o = active_q;

    // R4: a one-shot halt clears both the run bit and the status
    a_r4_halt_clears: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> (!run_q && !active_q));
    // R10: a software write takes effect even when a trigger is present
    a_r10_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (run_wr_i && !halt_i) |=> (run_q == $past(run_wdata_i)));
    // R9: the start action sets the run bit
    a_r9_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_en_i && trig_pulse_i && trig_act_i == 2'd0 && !run_wr_i && !halt_i)
        |=> run_q);
    // R7: the status cannot rise unless the run bit was set the cycle before
    a_r7_status_lags: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !run_q) |=> !active_q);
endmodule

// File: rtl/tpt_counter.sv
// Module: period counter with wrap, overflow pulse and a clear-when-stopped
// write. Assumes: active_i is the registered status from the run control.
module tpt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic             oneshot_i,
    input  logic             pie_i,
    input  logic             cnt_wr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             halt_o
);
    logic [CNT_W-1:0] count_q;
    logic             ovf_q;
    logic             at_end;

    assign at_end = (count_q == period_i);

    // Count, wrap on match, or clear on a write while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            ovf_q <= active_i && at_end;
            if (active_i) begin
                count_q <= at_end ? '0 : count_q + 1'b1;
            end else if (cnt_wr_i) begin
                count_q <= '0;
            end
        end
    end

    assign halt_o  = active_i && at_end && oneshot_i && pie_i;
    assign count_o = count_q;
    assign ovf_o   = ovf_q;

    // R1: an operating cycle below the period adds one
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !at_end) |=> (count_q == CNT_W'($past(count_q) + 1'b1)));
    // R2: a match wraps to zero and pulses overflow
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && at_end) |=> (count_q == '0 && ovf_q));
    // R2: overflow is only ever seen together with a zero count
    a_r2_ovf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (count_q == '0));
    // R5: a stopped counter holds its value without a write
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_i && !cnt_wr_i) |=> $stable(count_q));
    // R6: a write while stopped clears the count
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_i && cnt_wr_i) |=> (count_q == '0));
endmodule

// File: rtl/tpt_top.sv
// Module: triggerable period timer top. Joins trigger selection, run
// control and the counter. Assumes: one clock domain, synchronous
// active-low reset, register strobes one cycle wide.
module tpt_top #(
    parameter int CNT_W = 16,
    parameter int N_SRC = 4,
    localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    input  logic             oneshot_i,
    input  logic             pie_i,
    input  logic             run_wr_i,
    input  logic             run_wdata_i,
    input  logic             cnt_wr_i,
    input  logic             trig_en_i,
    input  logic [SRC_W-1:0] trig_src_i,
    input  logic [1:0]       trig_act_i,
    input  logic [N_SRC-1:0] trig_i,
    output logic             run_o,
    output logic             active_o,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);
    logic trig_pulse;
    logic halt;
    logic active;

    tpt_trig_sel #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (trig_i),
        .sel_i   (trig_src_i),
        .pulse_o (trig_pulse)
    );

    tpt_run_ctrl u_run (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_wr_i     (run_wr_i),
        .run_wdata_i  (run_wdata_i),
        .trig_en_i    (trig_en_i),
        .trig_act_i   (trig_act_i),
        .trig_pulse_i (trig_pulse),
        .halt_i       (halt),
        .run_o        (run_o),
        .active_o     (active)
    );

    tpt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (active),
        .period_i  (period_i),
        .oneshot_i (oneshot_i),
        .pie_i     (pie_i),
        .cnt_wr_i  (cnt_wr_i),
        .count_o   (count_o),
        .ovf_o     (ovf_o),
        .halt_o    (halt)
    );

    assign active_o = active;
endmodule

// File: tb/tpt_top_tb.sv
`timescale 1ns/1ps
module tpt_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] period_i = 16'd100;
    logic        oneshot_i = 1'b0;
    logic        pie_i = 1'b0;
    logic        run_wr_i = 1'b0;
    logic        run_wdata_i = 1'b0;
    logic        cnt_wr_i = 1'b0;
    logic        trig_en_i = 1'b0;
    logic [1:0]  trig_src_i = 2'd2;
    logic [1:0]  trig_act_i = 2'd0;
    logic [3:0]  trig_i = 4'd0;
    logic        run_o;
    logic        active_o;
    logic [15:0] count_o;
    logic        ovf_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    tpt_top u_dut (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .oneshot_i(oneshot_i),
        .pie_i(pie_i), .run_wr_i(run_wr_i), .run_wdata_i(run_wdata_i),
        .cnt_wr_i(cnt_wr_i), .trig_en_i(trig_en_i), .trig_src_i(trig_src_i),
        .trig_act_i(trig_act_i), .trig_i(trig_i), .run_o(run_o),
        .active_o(active_o), .count_o(count_o), .ovf_o(ovf_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sw_run(input logic v);
        run_wr_i = 1'b1; run_wdata_i = v;
        @(negedge clk);
        run_wr_i = 1'b0;
    endtask

    task automatic cnt_write();
        cnt_wr_i = 1'b1;
        @(negedge clk);
        cnt_wr_i = 1'b0;
    endtask

    task automatic trig_pulse(input int idx, input int hold);
        trig_i[idx] = 1'b1;
        tick(hold);
        trig_i[idx] = 1'b0;
        tick(1);
    endtask

    task automatic stop_and_clear();
        sw_run(1'b0);
        tick(2);
        cnt_write();
        oneshot_i = 1'b0; pie_i = 1'b0; period_i = 16'd100;
    endtask

    // Reset values
    task automatic t_reset();
        check("reset count", 32'(count_o), 0);
        check("reset run", 32'(run_o), 0);
        check("reset status", 32'(active_o), 0);
        check("reset ovf", 32'(ovf_o), 0);
    endtask

    // R1 R5 R7: start, count, stop holds, restart resumes
    task automatic t_run_stop();
        sw_run(1'b1);
        check("R7 run set", 32'(run_o), 1);
        check("R7 status lags", 32'(active_o), 0);
        tick(1);
        check("R7 status up", 32'(active_o), 1);
        check("R1 no count yet", 32'(count_o), 0);
        tick(1);
        check("R1 first step", 32'(count_o), 1);
        tick(5);
        check("R1 steady count", 32'(count_o), 6);
        sw_run(1'b0);
        check("R5 run cleared", 32'(run_o), 0);
        check("R5 extra step", 32'(count_o), 7);
        tick(1);
        check("R5 stopped value", 32'(count_o), 8);
        check("R7 status down", 32'(active_o), 0);
        tick(4);
        check("R5 hold", 32'(count_o), 8);
        sw_run(1'b1);
        tick(2);
        check("R5 resume", 32'(count_o), 9);
        tick(3);
        sw_run(1'b0);
        tick(1);
        check("R5 second stop", 32'(count_o), 14);
    endtask

    // R6: clear when stopped, ignored while running
    task automatic t_clear();
        cnt_write();
        check("R6 clear stopped", 32'(count_o), 0);
        sw_run(1'b1);
        tick(3);
        cnt_write();
        check("R6 ignored running", 32'(count_o), 3);
        sw_run(1'b0);
        tick(1);
        check("R6 count kept", 32'(count_o), 5);
        cnt_write();
        check("R6 clear again", 32'(count_o), 0);
    endtask

    // R2 R3: period 3 wraps and keeps going
    task automatic t_reload(input logic os, input logic ie);
        period_i = 16'd3; oneshot_i = os; pie_i = ie;
        sw_run(1'b1);
        tick(4);
        check("R2 at period", 32'(count_o), 3);
        check("R2 no early ovf", 32'(ovf_o), 0);
        tick(1);
        check("R2 wrap zero", 32'(count_o), 0);
        check("R2 ovf pulse", 32'(ovf_o), 1);
        tick(1);
        check("R3 continues", 32'(count_o), 1);
        check("R2 ovf one cycle", 32'(ovf_o), 0);
        check("R3 run kept", 32'(run_o), 1);
        tick(3);
        check("R3 second wrap ovf", 32'(ovf_o), 1);
        stop_and_clear();
    endtask

    // R4: one-shot with enable halts at the wrap
    task automatic t_oneshot();
        period_i = 16'd3; oneshot_i = 1'b1; pie_i = 1'b1;
        sw_run(1'b1);
        tick(5);
        check("R4 wrap ovf", 32'(ovf_o), 1);
        check("R4 run cleared", 32'(run_o), 0);
        check("R4 status cleared", 32'(active_o), 0);
        tick(3);
        check("R4 held zero", 32'(count_o), 0);
        check("R4 no more ovf", 32'(ovf_o), 0);
        stop_and_clear();
    endtask

    // R2: period zero overflows every operating cycle
    task automatic t_period_zero();
        int seen = 0;
        period_i = 16'd0;
        sw_run(1'b1);
        tick(1);
        for (int i = 0; i < 4; i++) begin
            tick(1);
            if (ovf_o === 1'b1) seen++;
        end
        check("R2 period zero ovf", 32'(seen), 4);
        stop_and_clear();
    endtask

    // R8 R9: source select, edge detection, action codes
    task automatic t_trigger();
        trig_en_i = 1'b1; trig_src_i = 2'd2; trig_act_i = 2'd0;
        trig_pulse(1, 2);
        check("R8 other source ignored", 32'(run_o), 0);
        trig_pulse(2, 3);
        check("R9 start", 32'(run_o), 1);
        trig_act_i = 2'd1;
        trig_pulse(2, 1);
        check("R9 stop", 32'(run_o), 0);
        trig_act_i = 2'd2;
        trig_pulse(2, 1);
        check("R9 toggle on", 32'(run_o), 1);
        trig_pulse(2, 1);
        check("R9 toggle off", 32'(run_o), 0);
        trig_pulse(2, 4);
        check("R8 level acts once", 32'(run_o), 1);
        trig_act_i = 2'd3;
        trig_pulse(2, 1);
        check("R9 none keeps", 32'(run_o), 1);
        sw_run(1'b0);
        trig_en_i = 1'b0; trig_act_i = 2'd0;
        trig_pulse(2, 1);
        check("R8 gating off", 32'(run_o), 0);
        stop_and_clear();
    endtask

    // R10: software write beats a same-cycle trigger
    task automatic t_priority();
        trig_en_i = 1'b1; trig_src_i = 2'd2; trig_act_i = 2'd0;
        trig_i[2] = 1'b1; run_wr_i = 1'b1; run_wdata_i = 1'b0;
        tick(1);
        run_wr_i = 1'b0; trig_i[2] = 1'b0;
        tick(1);
        check("R10 sw stop beats start", 32'(run_o), 0);
        sw_run(1'b1);
        trig_act_i = 2'd1;
        trig_i[2] = 1'b1; run_wr_i = 1'b1; run_wdata_i = 1'b1;
        tick(1);
        run_wr_i = 1'b0; trig_i[2] = 1'b0;
        tick(1);
        check("R10 sw run beats stop", 32'(run_o), 1);
        trig_en_i = 1'b0;
        stop_and_clear();
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_run_stop();
        t_clear();
        t_reload(1'b0, 1'b1);
        t_reload(1'b1, 1'b0);
        t_oneshot();
        t_period_zero();
        t_trigger();
        t_priority();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule